// File: doc/BRIEF.md
# Brownout Reset Release Sequencer

This block generates the internal reset of a small microcontroller core from two digitised supply-monitor flags. One flag reports that the supply is above the brownout threshold. The other reports that it is above a lower power-on trigger level. A millisecond tick paces a power-on delay, and an instruction-cycle tick paces an idle-timer countdown. Reset is released only after both conditions have been met, in order: first the delay expires, then the idle timer underflows.

A sag that stays above the trigger level re-presets only the idle timer. The supply recovers through the countdown alone. A deep sag below the trigger level also restarts the power-on delay. The external reset input is combined into the internal reset and reloads both the delay and the timer. A build parameter removes the brownout function, and the external reset is then the only source of the internal reset.

Top module: `bor_reset_seq`

## Requirements
- R1: While the synchronised above-brownout flag is low, `core_rst` is high. It rises at the third clock sample after the flag input falls.
- R2: Whenever the brownout logic holds reset, `idle_cnt` holds a preset in the range 0x00F0 to 0x00FF. Bits 15:8 are zero, bits 7:4 are 0xF, and bits 3:0 come from a free-running 4-bit counter.
- R3: The idle timer decrements once per `cyc_tick` only while the supply is above the brownout threshold and the delay has expired. `core_rst` falls on the tick at which the timer is at zero. With `cyc_tick` held high and the delay already expired, release comes 244 to 259 cycles after the flag input rises.
- R4: The countdown cannot start until `DLY_MS` millisecond ticks (default 3) have been counted while the supply is above the trigger level. Raising only the trigger flag never releases reset.
- R5: A dip below the trigger level clears the delay, so it must run again. A dip that stays above that level keeps the expired delay, and only the countdown repeats.
- R6: Once released, `core_rst` stays low for as long as the supply stays above the brownout threshold.
- R7: With `BROWNOUT_EN` = 0, `core_rst` equals `rst` at all times, regardless of the supply flags.
- R8: `rst` forces `core_rst` high in the same cycle. It also clears the delay and presets the timer, so that release afterwards needs the full delay followed by the countdown.
- R9: Both supply flags pass through two-flop synchronisers. A fall of the flag is not visible on `core_rst` at the second clock sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | External reset, active high, synchronous to clk |
| above_bor_i | input | 1 | Asynchronous flag: supply above brownout threshold |
| above_por_i | input | 1 | Asynchronous flag: supply above power-on trigger level |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cyc_tick | input | 1 | One-cycle pulse per instruction cycle |
| core_rst | output | 1 | Internal reset to the core, active high |
| idle_cnt | output | 16 | Current idle-timer value |

## Verification
The assertions assume that the two supply flags are consistent: the supply is never above the brownout threshold while below the lower trigger level. The bench therefore always drops the brownout flag together with, or before, the trigger flag, and raises it together with, or after, the trigger flag. The assertions also assume that each tick is a single-cycle pulse. The bench produces the millisecond tick from a divide-by-100 counter and holds the instruction tick high, which makes the release windows exact cycle ranges.

// File: rtl/bor_pkg.sv
package bor_pkg;
    localparam int IDLE_W = 16;
    localparam int NIB_W  = 4;

    typedef logic [IDLE_W-1:0] idle_t;
    typedef logic [NIB_W-1:0]  nib_t;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_COUNT,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic above_bor;
        logic above_por;
    } sup_flags_t;

    localparam idle_t PRESET_BASE = idle_t'(16'h00F0);

    // preset = 0x00F0 with the low nibble from the free-running counter
    function automatic idle_t preset_of(input nib_t nib);
        return PRESET_BASE | idle_t'(nib);
    endfunction
endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [0:STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bor_delay.sv
module bor_delay #(
    parameter int DLY_MS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic above_por,
    input  logic ms_tick,
    output logic done
);
    localparam int CW = $clog2(DLY_MS + 2);
    localparam logic [CW-1:0] LAST = CW'(DLY_MS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !above_por) cnt <= '0;
        else if (ms_tick && cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/bor_idle_fsm.sv
module bor_idle_fsm
    import bor_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  above_bor,
    input  logic  dly_done,
    input  logic  cyc_tick,
    input  nib_t  nib,
    output logic  hold,
    output idle_t tmr
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HOLD;
            tmr   <= preset_of(nib);
        end else begin
            unique case (state)
                ST_HOLD: begin
                    tmr <= preset_of(nib);
                    if (above_bor && dly_done) state <= ST_COUNT;
                end
                ST_COUNT: begin
                    if (!above_bor) begin
                        state <= ST_HOLD;
                        tmr   <= preset_of(nib);
                    end else if (cyc_tick) begin
                        if (tmr == '0) state <= ST_RUN;
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!above_bor) begin
                        state <= ST_HOLD;
                        tmr   <= preset_of(nib);
                    end else if (cyc_tick) begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: begin
                    state <= ST_HOLD;
                    tmr   <= preset_of(nib);
                end
            endcase
        end
    end

    assign hold = (state != ST_RUN);
endmodule

// File: rtl/bor_reset_seq.sv
module bor_reset_seq
    import bor_pkg::*;
#(
    parameter bit BROWNOUT_EN = 1'b1,
    parameter int DLY_MS      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              above_bor_i,
    input  logic              above_por_i,
    input  logic              ms_tick,
    input  logic              cyc_tick,
    output logic              core_rst,
    output logic [IDLE_W-1:0] idle_cnt
);
    sup_flags_t flags_raw, flags_s;
    logic ok_s, on_s, dly_done, ok_use, done_use, seq_hold;
    nib_t nib;

    assign flags_raw = '{above_bor: above_bor_i, above_por: above_por_i};

    bor_sync #(.W($bits(sup_flags_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(flags_raw), .q(flags_s)
    );

    assign ok_s = flags_s.above_bor;
    assign on_s = flags_s.above_por;

    bor_delay #(.DLY_MS(DLY_MS)) u_delay (
        .clk(clk), .rst(rst), .above_por(on_s), .ms_tick(ms_tick), .done(dly_done)
    );

    always_ff @(posedge clk) begin
        if (rst) nib <= '0;
        else     nib <= nib + 1'b1;
    end

    generate
        if (BROWNOUT_EN) begin : g_bor
            assign ok_use   = ok_s;
            assign done_use = dly_done;
            assign core_rst = rst | seq_hold;
        end else begin : g_nobor
            assign ok_use   = 1'b1;
            assign done_use = 1'b1;
            assign core_rst = rst;
        end
    endgenerate

    bor_idle_fsm u_fsm (
        .clk(clk), .rst(rst), .above_bor(ok_use), .dly_done(done_use),
        .cyc_tick(cyc_tick), .nib(nib), .hold(seq_hold), .tmr(idle_cnt)
    );
endmodule

// File: rtl/bor_reset_chk.sv
module bor_reset_chk
    import bor_pkg::*;
#(
    parameter bit BROWNOUT_EN = 1'b1
) (
    input logic  clk,
    input logic  rst,
    input logic  ok_s,
    input logic  on_s,
    input logic  dly_done,
    input logic  core_rst,
    input idle_t idle_cnt
);
    generate
        if (BROWNOUT_EN) begin : g_chk
            // R1
            sag_holds_reset_chk: assert property (@(posedge clk) disable iff (rst)
                !ok_s |=> core_rst);
            // R2
            preset_range_chk: assert property (@(posedge clk) disable iff (rst)
                !ok_s |=> (idle_cnt >= 16'h00F0 && idle_cnt <= 16'h00FF));
            // R4
            delay_gates_release_chk: assert property (@(posedge clk) disable iff (rst)
                !dly_done |=> core_rst);
            // R5
            deep_sag_clears_delay_chk: assert property (@(posedge clk) disable iff (rst)
                !on_s |=> !dly_done);
            // R3
            release_on_underflow_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(core_rst) |-> $past(idle_cnt) == '0);
            // R6
            stays_released_chk: assert property (@(posedge clk) disable iff (rst)
                (!core_rst && ok_s) |=> !core_rst);
        end
    endgenerate
endmodule

bind bor_reset_seq bor_reset_chk #(.BROWNOUT_EN(BROWNOUT_EN)) u_chk (
    .clk(clk), .rst(rst), .ok_s(ok_s), .on_s(on_s), .dly_done(dly_done),
    .core_rst(core_rst), .idle_cnt(idle_cnt)
);

// File: tb/tb_bor_reset_seq.sv
module tb_bor_reset_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic above_bor_i = 1'b0;
    logic above_por_i = 1'b0;
    logic ms_tick = 1'b0;
    logic cyc_tick = 1'b1;
    logic core_rst, core_rst_nb;
    logic [15:0] idle_cnt, idle_cnt_nb;
    int checks = 0;
    int fails = 0;
    int ms_div = 0;

    always #5 clk = ~clk;

    bor_reset_seq dut (
        .clk(clk), .rst(rst), .above_bor_i(above_bor_i), .above_por_i(above_por_i),
        .ms_tick(ms_tick), .cyc_tick(cyc_tick), .core_rst(core_rst), .idle_cnt(idle_cnt)
    );

    bor_reset_seq #(.BROWNOUT_EN(1'b0)) dut_nb (
        .clk(clk), .rst(rst), .above_bor_i(above_bor_i), .above_por_i(above_por_i),
        .ms_tick(ms_tick), .cyc_tick(cyc_tick), .core_rst(core_rst_nb), .idle_cnt(idle_cnt_nb)
    );

    // millisecond tick: one pulse every 100 cycles
    always @(negedge clk) begin
        if (ms_div == 99) begin ms_div = 0; ms_tick = 1'b1; end
        else begin ms_div = ms_div + 1; ms_tick = 1'b0; end
    end

    // 0 = shallow sag (brownout flag only), 1 = deep sag (both flags)
    localparam bit DEEP_TBL [0:5] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

    task automatic chk(input bit ok, input string req, input int act, input int lo, input int hi);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic measure(output int n);
        n = 0;
        while (core_rst && n < 800) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic hold_check(input int cyc, input string req);
        int bad = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (core_rst) bad++;
        end
        chk(bad == 0, req, bad, 0, 0);
    endtask

    initial begin
        int n;
        repeat (5) @(negedge clk);
        // reset state
        chk(core_rst == 1'b1, "R8 reset", core_rst, 1, 1);
        chk(core_rst_nb == 1'b1, "R7 reset", core_rst_nb, 1, 1);
        chk(idle_cnt >= 16'hF0 && idle_cnt <= 16'hFF, "R2 reset preset", idle_cnt, 240, 255);
        rst = 1'b0;
        repeat (50) @(negedge clk);
        chk(core_rst == 1'b1, "R1 unpowered", core_rst, 1, 1);
        chk(core_rst_nb == 1'b0, "R7 unpowered", core_rst_nb, 0, 0);
        // trigger level only: delay expires, still held
        above_por_i = 1'b1;
        repeat (400) @(negedge clk);
        chk(core_rst == 1'b1, "R4 trigger only", core_rst, 1, 1);
        above_bor_i = 1'b1;
        measure(n);
        chk(n >= 244 && n <= 259, "R3 release after expired delay", n, 244, 259);
        hold_check(300, "R6 stays released");

        // table of sags
        for (int v = 0; v < 6; v++) begin
            above_bor_i = 1'b0;
            if (DEEP_TBL[v]) above_por_i = 1'b0;
            repeat (2) @(negedge clk);
            chk(core_rst == 1'b0, "R9 sync latency", core_rst, 0, 0);
            @(negedge clk);
            chk(core_rst == 1'b1, "R1 sag asserts", core_rst, 1, 1);
            repeat (20) @(negedge clk);
            chk(idle_cnt >= 16'hF0 && idle_cnt <= 16'hFF, "R2 preset in sag", idle_cnt, 240, 255);
            chk(core_rst_nb == 1'b0, "R7 sag ignored", core_rst_nb, 0, 0);
            above_por_i = 1'b1;
            above_bor_i = 1'b1;
            measure(n);
            if (DEEP_TBL[v])
                chk(n >= 440 && n <= 570, "R5 deep sag reruns delay", n, 440, 570);
            else
                chk(n >= 244 && n <= 259, "R5 shallow sag skips delay", n, 244, 259);
            hold_check(150, "R6 stays released");
        end

        // external reset during run
        @(negedge clk);
        rst = 1'b1;
        #1;
        chk(core_rst == 1'b1, "R8 immediate", core_rst, 1, 1);
        chk(core_rst_nb == 1'b1, "R7 ext reset applies", core_rst_nb, 1, 1);
        repeat (3) @(negedge clk);
        chk(idle_cnt >= 16'hF0 && idle_cnt <= 16'hFF, "R8 timer reloaded", idle_cnt, 240, 255);
        rst = 1'b0;
        measure(n);
        chk(n >= 440 && n <= 570, "R8 delay reloaded", n, 440, 570);
        chk(core_rst_nb == 1'b0, "R7 after ext reset", core_rst_nb, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule